// File: doc/BRIEF.md
# UART Receive Status Tracker

This block follows the receive side of a UART whose characters land in a FIFO. A separate deserializer hands it each finished character together with a parity-error flag, a framing-error flag and a break flag. The block decides whether the character is stored. It passes accepted characters on to an external data FIFO. It keeps a shadow queue that holds only the error tags, so each tag stays attached to its character until the host pops that character.

From this state the block builds the receive half of a line-status word. That word has a data-ready bit, a sticky overrun bit, the three error tags of the character now at the head, and a summary flag that is set when any stored character is tagged. It also drives a line-status interrupt request that the host can mask.

A break stores a single zero character. Further input is then refused until the receive line has gone back to idle.

Top module: `rxs_status_top`

## Requirements
- R1: `data_ready` is 1 exactly when at least one character is stored; it rises in the cycle after the first push.
- R2: An accepted character appears on `push_en`/`push_data` combinationally in the same cycle that `char_valid` is high.
- R3: A character that completes while DEPTH characters are stored is not pushed, the stored characters are unchanged, and `overrun` is 1 from the next cycle.
- R4: `overrun` clears on a cycle with `status_rd` high; a new overrun event in that same cycle keeps it set.
- R5: `head_perr`, `head_ferr` and `head_brk` give the tags of the oldest stored character, and are all 0 while nothing is stored.
- R6: A character flagged as a break is stored as data 0x00 with its break and framing tags set and its parity tag clear.
- R7: After a break character is seen, every `char_valid` is ignored (no push, no overrun) until `rx_line` has been sampled high (1 = idle) on a clock edge.
- R8: `fifo_err` is 1 while any stored character carries a parity, framing or break tag, and 0 once none does.
- R9: `ls_irq` equals `irq_en` AND (`overrun` OR any head tag set).
- R10: A `pop` while nothing is stored has no effect on the stored count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| char_valid | input | 1 | Deserializer finished a character this cycle |
| char_data | input | 8 | Received character |
| char_perr | input | 1 | Character failed its parity check |
| char_ferr | input | 1 | Character had no valid stop bit |
| char_brk | input | 1 | Line was low for a whole frame |
| rx_line | input | 1 | Current receive line level, 1 = idle |
| pop | input | 1 | Host removes the oldest character |
| status_rd | input | 1 | Host reads the status word |
| irq_en | input | 1 | Line-status interrupt enable |
| push_en | output | 1 | Write strobe to the data FIFO |
| push_data | output | 8 | Data written to the data FIFO |
| data_ready | output | 1 | At least one character stored |
| overrun | output | 1 | Sticky overrun flag |
| head_perr | output | 1 | Parity tag of the head character |
| head_ferr | output | 1 | Framing tag of the head character |
| head_brk | output | 1 | Break tag of the head character |
| fifo_err | output | 1 | Some stored character is tagged |
| ls_irq | output | 1 | Line-status interrupt request |

## Verification
The bench builds the block with DEPTH = 4. With that depth the full-queue edge is reached after four pushes. Overrun, the drop of the extra character and the recovery by popping therefore fit into a short vector table. The same shallow queue keeps a tagged character in the middle while clean characters sit around it. This shows the head tags and the summary flag moving apart as entries are popped.

// File: rtl/rxs_pkg.sv
package rxs_pkg;
  typedef struct packed {
    logic brk;
    logic ferr;
    logic perr;
  } rxs_tag_t;

  localparam int TAG_W = $bits(rxs_tag_t);
endpackage

// File: rtl/rxs_accept.sv
module rxs_accept #(
  parameter int DATA_W = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 char_valid,
  input  logic [DATA_W-1:0]    char_data,
  input  logic                 char_perr,
  input  logic                 char_ferr,
  input  logic                 char_brk,
  input  logic                 rx_line,
  input  logic                 full,
  output logic                 push_en,
  output logic [DATA_W-1:0]    push_data,
  output rxs_pkg::rxs_tag_t    push_tag,
  output logic                 drop,
  output logic                 brk_hold
);
  logic brk_hold_nxt;
  logic accept;

  // a character counts only when no break is still pending
  assign accept = char_valid && !brk_hold;

  always_comb begin
    brk_hold_nxt = brk_hold;
    if (brk_hold && rx_line)
      brk_hold_nxt = 1'b0;
    else if (accept && char_brk)
      brk_hold_nxt = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      brk_hold <= 1'b0;
    else
      brk_hold <= brk_hold_nxt;
  end

  always_comb begin
    push_en   = accept && !full;
    drop      = accept && full;
    push_data = char_brk ? '0 : char_data;
    push_tag.brk  = char_brk;
    push_tag.ferr = char_ferr || char_brk;
    push_tag.perr = char_perr && !char_brk;
  end
endmodule

// File: rtl/rxs_tag_fifo.sv
module rxs_tag_fifo #(
  parameter int DEPTH = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 push,
  input  rxs_pkg::rxs_tag_t    push_tag,
  input  logic                 pop,
  output rxs_pkg::rxs_tag_t    head_tag,
  output logic                 pop_ok,
  output logic                 full,
  output logic [$clog2(DEPTH+1)-1:0] occ
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH+1);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

  rxs_pkg::rxs_tag_t slot [DEPTH];
  logic [PTR_W-1:0] wptr, wptr_nxt, rptr, rptr_nxt;
  logic [CNT_W-1:0] occ_nxt;
  logic empty;

  assign empty  = (occ == '0);
  assign full   = (occ == FULL_CNT);
  assign pop_ok = pop && !empty;

  always_comb begin
    wptr_nxt = wptr;
    rptr_nxt = rptr;
    occ_nxt  = occ;
    if (push)
      wptr_nxt = (wptr == LAST) ? '0 : wptr + 1'b1;
    if (pop_ok)
      rptr_nxt = (rptr == LAST) ? '0 : rptr + 1'b1;
    if (push && !pop_ok)
      occ_nxt = occ + 1'b1;
    else if (!push && pop_ok)
      occ_nxt = occ - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr <= '0;
      rptr <= '0;
      occ  <= '0;
    end else begin
      wptr <= wptr_nxt;
      rptr <= rptr_nxt;
      occ  <= occ_nxt;
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    logic we;
    assign we = push && (wptr == PTR_W'(g));
    always_ff @(posedge clk) begin
      if (we)
        slot[g] <= push_tag;
    end
  end

  assign head_tag = empty ? '0 : slot[rptr];
endmodule

// File: rtl/rxs_err_count.sv
module rxs_err_count #(
  parameter int DEPTH = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tagged_in,
  input  logic tagged_out,
  output logic any_err
);
  localparam int CNT_W = $clog2(DEPTH+1);

  logic [CNT_W-1:0] err_cnt, err_cnt_nxt;

  always_comb begin
    err_cnt_nxt = err_cnt;
    if (tagged_in && !tagged_out)
      err_cnt_nxt = err_cnt + 1'b1;
    else if (!tagged_in && tagged_out)
      err_cnt_nxt = err_cnt - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      err_cnt <= '0;
    else
      err_cnt <= err_cnt_nxt;
  end

  assign any_err = (err_cnt != '0);
endmodule

// File: rtl/rxs_status_top.sv
module rxs_status_top #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              char_valid,
  input  logic [DATA_W-1:0] char_data,
  input  logic              char_perr,
  input  logic              char_ferr,
  input  logic              char_brk,
  input  logic              rx_line,
  input  logic              pop,
  input  logic              status_rd,
  input  logic              irq_en,
  output logic              push_en,
  output logic [DATA_W-1:0] push_data,
  output logic              data_ready,
  output logic              overrun,
  output logic              head_perr,
  output logic              head_ferr,
  output logic              head_brk,
  output logic              fifo_err,
  output logic              ls_irq
);
  localparam int CNT_W = $clog2(DEPTH+1);

  logic rst_meta_n, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_n <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_n <= 1'b1;
      rst_sync_n <= rst_meta_n;
    end
  end

  rxs_pkg::rxs_tag_t push_tag, head_tag;
  logic drop, brk_hold, full, pop_ok, overrun_nxt;
  logic [CNT_W-1:0] occ;

  rxs_accept #(.DATA_W(DATA_W)) accept_i (
    .clk(clk), .rst_n(rst_sync_n),
    .char_valid(char_valid), .char_data(char_data),
    .char_perr(char_perr), .char_ferr(char_ferr), .char_brk(char_brk),
    .rx_line(rx_line), .full(full),
    .push_en(push_en), .push_data(push_data), .push_tag(push_tag),
    .drop(drop), .brk_hold(brk_hold)
  );

  rxs_tag_fifo #(.DEPTH(DEPTH)) tags_i (
    .clk(clk), .rst_n(rst_sync_n),
    .push(push_en), .push_tag(push_tag), .pop(pop),
    .head_tag(head_tag), .pop_ok(pop_ok), .full(full), .occ(occ)
  );

  rxs_err_count #(.DEPTH(DEPTH)) errs_i (
    .clk(clk), .rst_n(rst_sync_n),
    .tagged_in(push_en && (|push_tag)),
    .tagged_out(pop_ok && (|head_tag)),
    .any_err(fifo_err)
  );

  // a fresh overrun outranks the clearing read
  always_comb begin
    overrun_nxt = overrun;
    if (drop)
      overrun_nxt = 1'b1;
    else if (status_rd)
      overrun_nxt = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)
      overrun <= 1'b0;
    else
      overrun <= overrun_nxt;
  end

  assign data_ready = (occ != '0);
  assign head_perr  = head_tag.perr;
  assign head_ferr  = head_tag.ferr;
  assign head_brk   = head_tag.brk;
  assign ls_irq     = irq_en && (overrun || (|head_tag));
endmodule

// File: rtl/rxs_status_chk.sv
module rxs_status_chk #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              char_valid,
  input logic              char_brk,
  input logic              pop,
  input logic              irq_en,
  input logic              push_en,
  input logic [DATA_W-1:0] push_data,
  input logic              data_ready,
  input logic              overrun,
  input logic              head_perr,
  input logic              head_ferr,
  input logic              head_brk,
  input logic              fifo_err,
  input logic              ls_irq,
  input logic              brk_hold,
  input logic [$clog2(DEPTH+1)-1:0] occ
);
  a_r1_push_makes_ready: assert property (@(posedge clk) disable iff (!rst_n)
    push_en |=> data_ready);
  a_r3_full_blocks_push: assert property (@(posedge clk) disable iff (!rst_n)
    (occ == ($clog2(DEPTH+1))'(DEPTH)) |-> !push_en);
  a_r3_overrun_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (char_valid && !brk_hold && occ == ($clog2(DEPTH+1))'(DEPTH)) |=> overrun);
  a_r6_break_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (push_en && char_brk) |-> (push_data == '0));
  a_r7_hold_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    brk_hold |-> !push_en);
  a_r8_head_in_summary: assert property (@(posedge clk) disable iff (!rst_n)
    (head_perr || head_ferr || head_brk) |-> fifo_err);
  a_r9_overrun_irq: assert property (@(posedge clk) disable iff (!rst_n)
    (overrun && irq_en) |-> ls_irq);
  a_r10_empty_pop: assert property (@(posedge clk) disable iff (!rst_n)
    (occ == '0 && pop && !push_en) |=> (occ == '0));
endmodule

bind rxs_status_top rxs_status_chk #(.DATA_W(DATA_W), .DEPTH(DEPTH)) chk_i (
  .clk(clk), .rst_n(rst_sync_n), .char_valid(char_valid), .char_brk(char_brk),
  .pop(pop), .irq_en(irq_en), .push_en(push_en), .push_data(push_data),
  .data_ready(data_ready), .overrun(overrun), .head_perr(head_perr),
  .head_ferr(head_ferr), .head_brk(head_brk), .fifo_err(fifo_err),
  .ls_irq(ls_irq), .brk_hold(brk_hold), .occ(occ)
);

// File: tb/rxs_status_top_tb_top.sv
module rxs_status_top_tb_top;
  localparam int DATA_W = 8;
  localparam int DEPTH  = 4;
  localparam int NVEC   = 22;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n;
  logic char_valid, char_perr, char_ferr, char_brk, rx_line, pop, status_rd, irq_en;
  logic [DATA_W-1:0] char_data;
  logic push_en, data_ready, overrun, head_perr, head_ferr, head_brk, fifo_err, ls_irq;
  logic [DATA_W-1:0] push_data;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  rxs_status_top #(.DATA_W(DATA_W), .DEPTH(DEPTH)) dut_i (
    .clk(clk), .rst_n(rst_n), .char_valid(char_valid), .char_data(char_data),
    .char_perr(char_perr), .char_ferr(char_ferr), .char_brk(char_brk),
    .rx_line(rx_line), .pop(pop), .status_rd(status_rd), .irq_en(irq_en),
    .push_en(push_en), .push_data(push_data), .data_ready(data_ready),
    .overrun(overrun), .head_perr(head_perr), .head_ferr(head_ferr),
    .head_brk(head_brk), .fifo_err(fifo_err), .ls_irq(ls_irq)
  );

  // {valid,perr,ferr,brk} {data} {rx,pop,rd,ie} | expect {dr,ovr,hp,hf,hb,fe,irq}
  localparam logic [22:0] VEC [NVEC] = '{
    {4'b1000, 8'hA5, 4'b1001, 7'b1000000},  // R1 first push
    {4'b1100, 8'h3C, 4'b1001, 7'b1000010},  // R8 tagged behind clean head
    {4'b0000, 8'h00, 4'b1101, 7'b1010011},  // R5 R9 tagged at head
    {4'b1010, 8'h11, 4'b1001, 7'b1010011},  // R8
    {4'b1000, 8'h22, 4'b1001, 7'b1010011},  // R1
    {4'b1000, 8'h33, 4'b1001, 7'b1010011},  // R3 now full
    {4'b1000, 8'h44, 4'b1001, 7'b1110011},  // R3 overrun
    {4'b0000, 8'h00, 4'b1011, 7'b1010011},  // R4 read clears
    {4'b0000, 8'h00, 4'b1101, 7'b1001011},  // R5 framing head
    {4'b0000, 8'h00, 4'b1101, 7'b1000000},  // R8 summary clears
    {4'b1001, 8'hFF, 4'b0000, 7'b1000010},  // R6 break stored
    {4'b1001, 8'hFF, 4'b0000, 7'b1000010},  // R7 second break ignored
    {4'b1000, 8'h5A, 4'b0000, 7'b1000010},  // R7 char ignored
    {4'b0000, 8'h00, 4'b1000, 7'b1000010},  // R7 line idle
    {4'b0000, 8'h00, 4'b1101, 7'b1000010},  // R5
    {4'b0000, 8'h00, 4'b1101, 7'b1001111},  // R6 R9 break at head
    {4'b0000, 8'h00, 4'b1101, 7'b0000000},  // R7 nothing extra stored
    {4'b1000, 8'h77, 4'b1001, 7'b1000000},  // R7 accepts after idle
    {4'b0000, 8'h00, 4'b1101, 7'b0000000},  // R1
    {4'b0000, 8'h00, 4'b1101, 7'b0000000},  // R10 pop on empty
    {4'b1000, 8'h88, 4'b1001, 7'b1000000},  // R10
    {4'b0000, 8'h00, 4'b1101, 7'b0000000}   // R10 single entry
  };
  localparam int VREQ [NVEC] = '{1,8,5,8,1,3,3,4,5,8,6,7,7,7,5,6,7,7,1,10,10,10};

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic drive(input logic [15:0] s);
    {char_valid, char_perr, char_ferr, char_brk} = s[15:12];
    char_data = s[11:4];
    {rx_line, pop, status_rd, irq_en} = s[3:0];
  endtask

  function automatic logic [6:0] outs();
    return {data_ready, overrun, head_perr, head_ferr, head_brk, fifo_err, ls_irq};
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    drive(16'h0008);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 reset", {25'd0, outs()}, 32'd0);
    chk("R5 reset push", {31'd0, push_en}, 32'd0);

    for (int i = 0; i < NVEC; i++) begin
      @(negedge clk);
      drive(VEC[i][22:7]);
      @(posedge clk);
      #1;
      chk($sformatf("R%0d vec%0d", VREQ[i], i), {25'd0, outs()}, {25'd0, VEC[i][6:0]});
    end

    // R2 and R6: push strobe and data in the same cycle
    @(negedge clk);
    drive({4'b1001, 8'hC3, 4'b1000});
    #1;
    chk("R6 break data", {23'd0, push_en, push_data}, {23'd0, 1'b1, 8'h00});
    @(negedge clk);
    drive({4'b0000, 8'h00, 4'b1101});
    @(negedge clk);
    drive({4'b1000, 8'h5E, 4'b1000});
    #1;
    chk("R2 same-cycle push", {23'd0, push_en, push_data}, {23'd0, 1'b1, 8'h5E});
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      drive({4'b1000, 8'(k), 4'b1000});
    end
    @(negedge clk);
    drive({4'b1000, 8'h99, 4'b1010});
    #1;
    chk("R3 no push when full", {31'd0, push_en}, 32'd0);
    @(posedge clk);
    #1;
    chk("R4 set beats read", {31'd0, overrun}, 32'd1);
    @(negedge clk);
    drive({4'b0000, 8'h00, 4'b1010});
    @(posedge clk);
    #1;
    chk("R4 read clears", {31'd0, overrun}, 32'd0);
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      drive({4'b0000, 8'h00, 4'b1100});
      @(posedge clk);
      #1;
      chk("R3 contents kept", {31'd0, data_ready}, (k == 3) ? 32'd0 : 32'd1);
    end
    @(negedge clk);
    drive(16'h0008);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule